// File: doc/BRIEF.md
# Carrier PWM Arm Modulator with Last-Level Mode

This block drives the module gates of one converter arm. Each cycle it walks the arm's modules in a supplied priority order and switches on every module whose voltage still fits under the arm reference. The sum stays at or below the reference. The first module that does not fit is the one that can be pulse-width modulated. Its duty is the leftover voltage divided by that same module's voltage, and it is compared against an internal triangular carrier.

A mode input chooses between two strategies. In all-levels mode the leftover is always modulated. In last-level mode modulation is kept to the two outermost bands, next to the upper and lower arm boundary references. Everywhere between them the block rounds to the nearest level, which cuts the number of commutations. The carrier is locked to the output waveform: one output period always holds a whole multiple of three carrier periods. The carrier half-period has a lower bound, which caps the carrier frequency.

Top module: `amod_arm_modulator`

## Requirements
- R1: While `rst_n` is low, `mod_en` is all zeros. After reset, `mod_en` is registered and shows, one clock later, the decision made from the inputs and carrier position of the cycle before that edge.
- R2: Module `i` has its voltage at `mod_v[i*VW +: VW]`. Priority slot `s` holds a module index at `prio[s*IW +: IW]`, and slot 0 is served first. Modules are enabled slot by slot while the running voltage sum including the module stays at or below `arm_ref`. The walk stops at the first module that would exceed it, so no module in a later slot is enabled, even a smaller one that would fit.
- R3: Only the module in the stopping slot can be modulated. It is on in a cycle exactly when residual × H > c × v, where the residual is `arm_ref` minus the enabled sum, v is that module's voltage, c is the carrier level and H is the carrier half-period.
- R4: A residual of zero leaves the candidate module off at every carrier level, including level 0. The residual is clamped to the candidate's voltage before the comparison.
- R5: When every module fits under `arm_ref`, all modules are enabled and `mod_en` does not vary with the carrier.
- R6: The carrier level runs 0, 1, …, H, H−1, …, 1 and then repeats, with a period of 2H cycles. H is `car_half`, raised to MIN_HALF when smaller.
- R7: One output period is 3·M carrier periods, where M is `ratio_m`, or 1 when `ratio_m` is zero. `car_half` and `ratio_m` are sampled only in the first cycle of each output period, and changes made mid-period wait for the next one. The first output period starts in the first cycle after reset.
- R8: With `mode`=1, the candidate is modulated only in the top band, where the enabled sum plus the candidate voltage exceeds `bnd_hi`, or in the bottom band, where the enabled sum is at or below `bnd_lo`.
- R9: With `mode`=1 and the reference outside both bands, the candidate is switched fully on when twice the residual exceeds its voltage, and otherwise stays off. A tie rounds down.
- R10: With `mode`=0, every residual is modulated, and `bnd_hi` and `bnd_lo` have no effect on `mod_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = all-levels PWM, 1 = last-level PWM |
| arm_ref | input | VW | Arm voltage reference |
| bnd_hi | input | VW | Upper boundary arm reference |
| bnd_lo | input | VW | Lower boundary arm reference |
| mod_v | input | N_MOD*VW | Per-module voltages, module i at bits i*VW |
| prio | input | N_MOD*IW | Priority slots, slot 0 first, each holding a module index |
| car_half | input | HW | Requested carrier half-period in cycles |
| ratio_m | input | MW | Output period in units of three carrier periods |
| mod_en | output | N_MOD | Module enables |

## Verification
Every gating decision appears on `mod_en` exactly one clock after the cycle whose inputs and carrier position produced it. The bench therefore computes the expected enables at the falling edge before the deciding rising edge and queues them. A monitor compares them shortly after that rising edge. Carrier-setting changes act only at the next output-period start (R7), so the bench keeps its own carrier position and period count from reset and applies the same period-start sampling rule. Inputs change only at falling edges, so the values the design samples are the ones the expected result was built from.

// File: rtl/amod_pkg.sv
package amod_pkg;
  typedef enum logic {
    MOD_ALL_LEVELS = 1'b0,
    MOD_LAST_LEVEL = 1'b1
  } amod_mode_e;
endpackage

// File: rtl/amod_carrier.sv
module amod_carrier #(
  parameter int HW       = 8,
  parameter int MW       = 4,
  parameter int MIN_HALF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] half_in,
  input  logic [MW-1:0] ratio_in,
  output logic [HW-1:0] car_o,
  output logic [HW-1:0] half_o
);
  localparam int PW = HW + 1;
  localparam int CW = MW + 2;

  logic [PW-1:0] pos_q;
  logic [CW-1:0] cnt_q;
  logic [HW-1:0] half_q;
  logic [MW-1:0] m_q;

  logic          at_start;
  logic [HW-1:0] half_live, half_eff;
  logic [MW-1:0] m_live, m_eff;
  logic [CW-1:0] cnt_lim;
  logic          pos_wrap, cnt_wrap;

  function automatic logic [HW-1:0] car_of(input logic [PW-1:0] pos, input logic [HW-1:0] h);
    if (pos < {1'b0, h}) return pos[HW-1:0];
    return HW'({h, 1'b0} - pos);
  endfunction

  always_comb begin
    at_start  = (pos_q == '0) && (cnt_q == '0);
    half_live = (half_in < HW'(MIN_HALF)) ? HW'(MIN_HALF) : half_in;
    m_live    = (ratio_in == '0) ? MW'(1) : ratio_in;
    half_eff  = at_start ? half_live : half_q;
    m_eff     = at_start ? m_live : m_q;
    cnt_lim   = CW'(m_eff) * CW'(3) - CW'(1);
    pos_wrap  = (pos_q == ({half_eff, 1'b0} - PW'(1)));
    cnt_wrap  = (cnt_q == cnt_lim);
    car_o     = car_of(pos_q, half_eff);
    half_o    = half_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      cnt_q  <= '0;
      half_q <= HW'(MIN_HALF);
      m_q    <= MW'(1);
    end else begin
      if (at_start) begin
        half_q <= half_live;
        m_q    <= m_live;
      end
      if (pos_wrap) begin
        pos_q <= '0;
        cnt_q <= cnt_wrap ? '0 : cnt_q + CW'(1);
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end
  end

  // R6: carrier level never rises above the half-period in force
  p_car_peak_r6: assert property (@(posedge clk) disable iff (!rst_n)
    car_o <= half_o);

  // R7: settings in force change only at an output-period start
  p_hold_settings_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !at_start |-> (half_eff == $past(half_eff) && m_eff == $past(m_eff)));
endmodule

// File: rtl/amod_fill.sv
module amod_fill #(
  parameter int N_MOD = 4,
  parameter int VW    = 10,
  parameter int IW    = 2,
  parameter int SW    = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VW-1:0]       arm_ref,
  input  logic [N_MOD*VW-1:0] mod_v,
  input  logic [N_MOD*IW-1:0] prio,
  output logic [N_MOD-1:0]    fill_mask,
  output logic [SW-1:0]       fill_sum,
  output logic                has_next,
  output logic [IW-1:0]       next_idx,
  output logic [VW-1:0]       next_v
);
  always_comb begin
    fill_mask = '0;
    fill_sum  = '0;
    has_next  = 1'b0;
    next_idx  = '0;
    next_v    = '0;
    for (int s = 0; s < N_MOD; s++) begin
      logic [IW-1:0] id;
      logic [VW-1:0] v;
      id = prio[s*IW +: IW];
      v  = mod_v[id*VW +: VW];
      if (!has_next) begin
        if (fill_sum + SW'(v) <= SW'(arm_ref)) begin
          fill_mask[id] = 1'b1;
          fill_sum      = fill_sum + SW'(v);
        end else begin
          has_next = 1'b1;
          next_idx = id;
          next_v   = v;
        end
      end
    end
  end

  // R2: enabled sum never overshoots the reference
  p_fill_under_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_sum <= SW'(arm_ref));

  // R2: the walk stops only where the next module would overshoot
  p_fill_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    has_next |-> (fill_sum + SW'(next_v) > SW'(arm_ref)));

  // R3: the candidate is not already among the enabled modules
  p_next_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    has_next |-> !fill_mask[next_idx]);
endmodule

// File: rtl/amod_decide.sv
module amod_decide
  import amod_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int VW    = 10,
  parameter int IW    = 2,
  parameter int SW    = 13,
  parameter int HW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  amod_mode_e       mode,
  input  logic [VW-1:0]    arm_ref,
  input  logic [VW-1:0]    bnd_hi,
  input  logic [VW-1:0]    bnd_lo,
  input  logic [N_MOD-1:0] fill_mask,
  input  logic [SW-1:0]    fill_sum,
  input  logic             has_next,
  input  logic [IW-1:0]    next_idx,
  input  logic [VW-1:0]    next_v,
  input  logic [HW-1:0]    car,
  input  logic [HW-1:0]    half,
  output logic [N_MOD-1:0] en_c
);
  localparam int PW = VW + HW;

  logic [VW-1:0] residual, res_sat;
  logic          top_band, bot_band, pwm_zone, pwm_on, nlc_up;

  // residual/v > car/half, compared without a divider
  function automatic logic duty_on(input logic [VW-1:0] res, input logic [VW-1:0] v,
                                   input logic [HW-1:0] c, input logic [HW-1:0] h);
    return (PW'(res) * PW'(h)) > (PW'(c) * PW'(v));
  endfunction

  always_comb begin
    residual = VW'(SW'(arm_ref) - fill_sum);
    res_sat  = (residual > next_v) ? next_v : residual;
    top_band = (fill_sum + SW'(next_v)) > SW'(bnd_hi);
    bot_band = fill_sum <= SW'(bnd_lo);
    pwm_zone = has_next && ((mode == MOD_ALL_LEVELS) || top_band || bot_band);
    pwm_on   = pwm_zone && duty_on(res_sat, next_v, car, half);
    nlc_up   = has_next && !pwm_zone && ({1'b0, residual, 1'b0} > {2'b00, next_v});
    en_c     = fill_mask;
    if (pwm_on || nlc_up) en_c[next_idx] = 1'b1;
  end

  // R3: at most the single candidate module differs from the filled set
  p_one_extra_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en_c ^ fill_mask) <= 1);

  // R5: nothing left to modulate when every module fits
  p_full_static_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !has_next |-> (en_c == fill_mask));

  // R4: a zero residual never switches the candidate on
  p_zero_res_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (has_next && residual == '0) |-> (en_c == fill_mask));
endmodule

// File: rtl/amod_arm_modulator.sv
module amod_arm_modulator
  import amod_pkg::*;
#(
  parameter int N_MOD    = 4,
  parameter int VW       = 10,
  parameter int HW       = 8,
  parameter int MW       = 4,
  parameter int MIN_HALF = 4,
  parameter int IW       = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode,
  input  logic [VW-1:0]       arm_ref,
  input  logic [VW-1:0]       bnd_hi,
  input  logic [VW-1:0]       bnd_lo,
  input  logic [N_MOD*VW-1:0] mod_v,
  input  logic [N_MOD*IW-1:0] prio,
  input  logic [HW-1:0]       car_half,
  input  logic [MW-1:0]       ratio_m,
  output logic [N_MOD-1:0]    mod_en
);
  localparam int SW = VW + IW + 1;

  logic [HW-1:0]    car, half;
  logic [N_MOD-1:0] fill_mask, en_c;
  logic [SW-1:0]    fill_sum;
  logic             has_next;
  logic [IW-1:0]    next_idx;
  logic [VW-1:0]    next_v;
  amod_mode_e       mode_e;

  assign mode_e = amod_mode_e'(mode);

  amod_carrier #(.HW(HW), .MW(MW), .MIN_HALF(MIN_HALF)) u_car (
    .clk(clk), .rst_n(rst_n), .half_in(car_half), .ratio_in(ratio_m),
    .car_o(car), .half_o(half)
  );

  amod_fill #(.N_MOD(N_MOD), .VW(VW), .IW(IW), .SW(SW)) u_fill (
    .clk(clk), .rst_n(rst_n), .arm_ref(arm_ref), .mod_v(mod_v), .prio(prio),
    .fill_mask(fill_mask), .fill_sum(fill_sum), .has_next(has_next),
    .next_idx(next_idx), .next_v(next_v)
  );

  amod_decide #(.N_MOD(N_MOD), .VW(VW), .IW(IW), .SW(SW), .HW(HW)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .arm_ref(arm_ref),
    .bnd_hi(bnd_hi), .bnd_lo(bnd_lo), .fill_mask(fill_mask), .fill_sum(fill_sum),
    .has_next(has_next), .next_idx(next_idx), .next_v(next_v),
    .car(car), .half(half), .en_c(en_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mod_en <= '0;
    else        mod_en <= en_c;
  end

  // R1: output is one registered step behind the decision logic
  p_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (mod_en == $past(en_c)));
endmodule

// File: tb/amod_arm_modulator_tb.sv
module amod_arm_modulator_tb;
  localparam int N = 4, VW = 10, HW = 8, MW = 4, MIN_HALF = 4, IW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            mode_i = 1'b0;
  logic [VW-1:0]   ref_i = '0, hi_i = '0, lo_i = '0;
  logic [N*VW-1:0] mod_v;
  logic [N*IW-1:0] prio;
  logic [HW-1:0]   chalf = 8'd5;
  logic [MW-1:0]   rm = 4'd1;
  logic [N-1:0]    mod_en;

  int vol[N];
  int pr[N];
  int checks = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [N-1:0] en; string tag; } item_t;
  item_t q[$];

  int b_pos = 0, b_cnt = 0, b_h = MIN_HALF, b_m = 1;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      mod_v[i*VW +: VW] = vol[i][VW-1:0];
      prio[i*IW +: IW]  = pr[i][IW-1:0];
    end
  end

  amod_arm_modulator #(.N_MOD(N), .VW(VW), .HW(HW), .MW(MW), .MIN_HALF(MIN_HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode_i), .arm_ref(ref_i), .bnd_hi(hi_i),
    .bnd_lo(lo_i), .mod_v(mod_v), .prio(prio), .car_half(chalf), .ratio_m(rm),
    .mod_en(mod_en)
  );

  function automatic logic [N-1:0] model_en(int c, int h);
    logic [N-1:0] e;
    int sum, nx, nv, r;
    bit stop, zone;
    e = '0; sum = 0; nx = 0; nv = 0; stop = 0;
    for (int s = 0; s < N; s++) begin
      int id;
      id = pr[s];
      if (!stop) begin
        if (sum + vol[id] <= int'(ref_i)) begin e[id] = 1'b1; sum += vol[id]; end
        else begin stop = 1; nx = id; nv = vol[id]; end
      end
    end
    if (stop) begin
      r = int'(ref_i) - sum;
      zone = (mode_i == 1'b0) || (sum + nv > int'(hi_i)) || (sum <= int'(lo_i));
      if (zone) begin
        if (r * h > c * nv) e[nx] = 1'b1;
      end else if (2 * r > nv) e[nx] = 1'b1;
    end
    return e;
  endfunction

  // driver: expectation for the next rising edge, then wait for the falling edge
  task automatic step(string tag);
    int h, m, c;
    item_t it;
    bit st;
    st = (b_pos == 0) && (b_cnt == 0);
    h = st ? ((int'(chalf) < MIN_HALF) ? MIN_HALF : int'(chalf)) : b_h;
    m = st ? ((rm == 0) ? 1 : int'(rm)) : b_m;
    if (st) begin b_h = h; b_m = m; end
    c = (b_pos < h) ? b_pos : 2 * h - b_pos;
    it.en = model_en(c, h);
    it.tag = tag;
    q.push_back(it);
    if (b_pos == 2 * h - 1) begin
      b_pos = 0;
      b_cnt = (b_cnt == 3 * m - 1) ? 0 : b_cnt + 1;
    end else b_pos++;
    @(negedge clk);
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (mod_en !== it.en) begin
          bad++;
          $display("FAIL %s: mod_en=%b expected %b", it.tag, mod_en, it.en);
        end
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    vol = '{100, 60, 40, 80};
    pr  = '{1, 3, 0, 2};
    ref_i = 10'd170;
    repeat (3) @(negedge clk);
    checks++;
    if (mod_en !== 4'b0000) begin
      bad++;
      $display("FAIL R1: mod_en=%b expected %b", mod_en, 4'b0000);
    end
    rst_n = 1'b1;
    b_pos = 0; b_cnt = 0;
    // R2 R3: fill to 140, modulate module 0 with residual 30 of 100
    run(40, "R3 all-levels duty");
    // R2: stop at first misfit, later smaller module stays off
    pr = '{0, 2, 3, 1}; ref_i = 10'd205;
    run(30, "R2 stop at first misfit");
    // R4: exact sum and zero reference
    ref_i = 10'd140;
    run(20, "R4 zero residual exact");
    ref_i = 10'd0;
    run(20, "R4 zero residual empty");
    // R5: everything fits
    ref_i = 10'd300;
    run(15, "R5 all enabled");
    ref_i = 10'd280;
    run(15, "R5 all enabled exact");
    // R6: half-period below the floor, then a wider carrier
    ref_i = 10'd230; chalf = 8'd2;
    run(70, "R6 floor half-period");
    chalf = 8'd7;
    run(60, "R6 wide carrier");
    // R7: mid-period changes wait for the period start
    rm = 4'd2; chalf = 8'd5;
    run(37, "R7 ratio two");
    chalf = 8'd9; rm = 4'd1;
    run(90, "R7 mid-period change");
    // R8: last-level bands
    chalf = 8'd5;
    mode_i = 1'b1; pr = '{1, 3, 0, 2}; hi_i = 10'd250; lo_i = 10'd70;
    ref_i = 10'd250;
    run(30, "R8 top band pwm");
    ref_i = 10'd65;
    run(30, "R8 bottom band pwm");
    // R9: nearest level in the middle
    ref_i = 10'd150;
    run(15, "R9 round down");
    ref_i = 10'd200;
    run(15, "R9 round up");
    ref_i = 10'd190;
    run(15, "R9 tie rounds down");
    // R10: bounds ignored in all-levels mode
    mode_i = 1'b0; ref_i = 10'd150;
    run(25, "R10 bounds set");
    hi_i = 10'd0; lo_i = 10'd0;
    run(25, "R10 bounds cleared");
    hi_i = 10'd1000; lo_i = 10'd1000;
    run(25, "R10 bounds high");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule